// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked host read and write an external asynchronous static RAM of 8-bit words. The host presents a strobe with a read/write flag, a word address and write data. The block then drives the memory's active-low select, write and output-enable strobes for a fixed number of clock cycles. Those cycle counts are chosen so that each access meets the memory's minimum cycle, pulse, setup and hold times at the system clock rate. The data bus is split into an output value, an input value and a driver enable, so the pad ring can build the tristate pin outside the block.

Only one request is in flight at a time. The block drops `ready` while it works. When the access finishes it raises `rsp_done` for one clock. Read data stays on `rsp_rdata` until the next read completes. Every write is made with output enable held inactive, so the memory can use its shorter write pulse. When the direction of transfer changes, the block inserts idle clocks with the bus driver off, so the two sides never drive the data lines at the same time.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_done` is 0 and `ready` is 1.
- R2: The strobes only ever form one of three patterns: deselected (cs_n=1, we_n=1, oe_n=1), read (cs_n=0, we_n=1, oe_n=0) or write (cs_n=0, we_n=0, oe_n=1). we_n is never low while oe_n is low.
- R3: A read holds cs_n and oe_n low for RD_CYC clocks. It samples `mem_dq_in` on the clock edge that ends the last of them, and presents that value on `rsp_rdata`.
- R4: A write holds cs_n and we_n low together for WR_CYC clocks, with data driven from the first of them. The strobes then rise, and the address, the data and the driver enable stay unchanged for WR_HOLD more clocks.
- R5: `mem_addr` does not change while cs_n stays low.
- R6: When an access runs in the opposite direction to the previous one, TURN_CYC clocks with all strobes inactive and the driver off come before it. The read strobe never follows a driven cycle directly, and the driver never follows a read cycle directly.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R8: `ready` is 1 only while idle. A request raised while `ready` is 0 is ignored and causes no access.
- R9: `rsp_done` is a one-clock pulse. Counted in clock edges after the edge that accepts the request, it appears RD_CYC edges later for a read and WR_CYC+WR_HOLD edges later for a write, plus TURN_CYC when a turnaround is inserted.
- R10: `rsp_rdata` keeps its value through writes until the next read completes.
- R11: Two accesses in the same direction run with no turnaround clocks between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, taken when ready is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Last read data |
| rsp_done | output | 1 | One-clock completion pulse |
| ready | output | 1 | Idle, able to take a request |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data toward memory |
| mem_dq_in | input | DATA_W | Data from memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The bench builds the block with ADDR_W=6, with the default timing counts RD_CYC=2, WR_CYC=2, WR_HOLD=1 and TURN_CYC=1. The narrow address makes it practical to write, read back and then alternately rewrite and reread every one of the 64 words. This exercises same-direction runs and a turnaround on every access. A behavioural memory model stores data only at the end of a write strobe, and returns data only in read mode, so every strobe width, hold cycle and turnaround gap shows up in the data read back and in the latencies measured.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_RD,
      ST_WR,
      ST_REC
   } asram_st_e;

   typedef struct packed {
      logic cs_n;
      logic we_n;
      logic oe_n;
      logic drv;
   } asram_pins_t;

   function automatic asram_pins_t pins_for(asram_st_e s);
      asram_pins_t p;
      p.cs_n = 1'b1;
      p.we_n = 1'b1;
      p.oe_n = 1'b1;
      p.drv  = 1'b0;
      case (s)
         ST_RD: begin
            p.cs_n = 1'b0;
            p.oe_n = 1'b0;
         end
         ST_WR: begin
            p.cs_n = 1'b0;
            p.we_n = 1'b0;
            p.drv  = 1'b1;
         end
         ST_REC: p.drv = 1'b1;
         default: ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int RD_CYC   = 2,
   parameter int WR_CYC   = 2,
   parameter int WR_HOLD  = 1,
   parameter int TURN_CYC = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req,
   input  logic      req_we,
   output asram_st_e state_q,
   output asram_st_e nxt_state,
   output logic      accept,
   output logic      cap_en,
   output logic      fin
);

   localparam int MAXA  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
   localparam int MAXB  = (WR_HOLD > TURN_CYC) ? WR_HOLD : TURN_CYC;
   localparam int MAXC  = (MAXA > MAXB) ? MAXA : MAXB;
   localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
   localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] HD_LOAD = CNT_W'((WR_HOLD > 0) ? WR_HOLD - 1 : 0);
   localparam logic [CNT_W-1:0] TN_LOAD = CNT_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);
   localparam bit HAS_HOLD = (WR_HOLD > 0);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             op_we_q, op_we_d;
   logic             last_we_q;
   logic             prev_q;
   logic             need_turn;

   generate
      if (TURN_CYC > 0) begin : g_turn
         assign need_turn = prev_q && (last_we_q != req_we);
      end else begin : g_noturn
         assign need_turn = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt_state = state_q;
      cnt_d     = cnt_q;
      op_we_d   = op_we_q;
      accept    = 1'b0;
      cap_en    = 1'b0;
      fin       = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (req) begin
               accept  = 1'b1;
               op_we_d = req_we;
               if (need_turn) begin
                  nxt_state = ST_TURN;
                  cnt_d     = TN_LOAD;
               end else if (req_we) begin
                  nxt_state = ST_WR;
                  cnt_d     = WR_LOAD;
               end else begin
                  nxt_state = ST_RD;
                  cnt_d     = RD_LOAD;
               end
            end
         end
         ST_TURN: begin
            if (cnt_q == '0) begin
               nxt_state = op_we_q ? ST_WR : ST_RD;
               cnt_d     = op_we_q ? WR_LOAD : RD_LOAD;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_RD: begin
            if (cnt_q == '0) begin
               nxt_state = ST_IDLE;
               cap_en    = 1'b1;
               fin       = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_WR: begin
            if (cnt_q == '0) begin
               if (HAS_HOLD) begin
                  nxt_state = ST_REC;
                  cnt_d     = HD_LOAD;
               end else begin
                  nxt_state = ST_IDLE;
                  fin       = 1'b1;
               end
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_REC: begin
            if (cnt_q == '0) begin
               nxt_state = ST_IDLE;
               fin       = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: nxt_state = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         op_we_q   <= 1'b0;
         last_we_q <= 1'b0;
         prev_q    <= 1'b0;
      end else begin
         state_q <= nxt_state;
         cnt_q   <= cnt_d;
         op_we_q <= op_we_d;
         if (accept) begin
            last_we_q <= req_we;
            prev_q    <= 1'b1;
         end
      end
   end

   // R8: once busy, the sequencer stays away from idle until an access finishes
   a_r8_busy_until_fin: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !fin) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/asram_pins.sv
module asram_pins
   import asram_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  asram_st_e         nxt_state,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic              mem_dq_oe
);

   asram_pins_t pin_d;

   always_comb pin_d = pins_for(nxt_state);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_cs_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         mem_cs_n  <= pin_d.cs_n;
         mem_we_n  <= pin_d.we_n;
         mem_oe_n  <= pin_d.oe_n;
         mem_dq_oe <= pin_d.drv;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr   <= '0;
         mem_dq_out <= '0;
      end else if (accept) begin
         mem_addr   <= req_addr;
         mem_dq_out <= req_wdata;
      end
   end

   // R5: address stays put across consecutive selected cycles
   a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/asram_rsp.sv
module asram_rsp #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              fin,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         rsp_done  <= 1'b0;
      end else begin
         rsp_done <= fin;
         if (cap_en) rsp_rdata <= mem_dq_in;
      end
   end

   // R9: completion is a single-cycle pulse
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
   import asram_pkg::*;
#(
   parameter int ADDR_W   = 19,
   parameter int DATA_W   = 8,
   parameter int RD_CYC   = 2,
   parameter int WR_CYC   = 2,
   parameter int WR_HOLD  = 1,
   parameter int TURN_CYC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_done,
   output logic              ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              mem_dq_oe
);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("asram_ctrl: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("asram_ctrl: DATA_W must be positive");
      end
      if (RD_CYC < 1 || WR_CYC < 1) begin : g_bad_cyc
         $error("asram_ctrl: strobe lengths must be at least one clock");
      end
      if (WR_HOLD < 0 || TURN_CYC < 0) begin : g_bad_gap
         $error("asram_ctrl: hold and turnaround counts cannot be negative");
      end
   endgenerate

   asram_st_e state_q, nxt_state;
   logic      accept, cap_en, fin;

   asram_seq #(
      .RD_CYC  (RD_CYC),
      .WR_CYC  (WR_CYC),
      .WR_HOLD (WR_HOLD),
      .TURN_CYC(TURN_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_we   (req_we),
      .state_q  (state_q),
      .nxt_state(nxt_state),
      .accept   (accept),
      .cap_en   (cap_en),
      .fin      (fin)
   );

   asram_pins #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_state (nxt_state),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_addr  (mem_addr),
      .mem_dq_out(mem_dq_out),
      .mem_cs_n  (mem_cs_n),
      .mem_we_n  (mem_we_n),
      .mem_oe_n  (mem_oe_n),
      .mem_dq_oe (mem_dq_oe)
   );

   asram_rsp #(
      .DATA_W(DATA_W)
   ) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .fin      (fin),
      .mem_dq_in(mem_dq_in),
      .rsp_rdata(rsp_rdata),
      .rsp_done (rsp_done)
   );

   assign ready = (state_q == ST_IDLE);

   // R2: write strobe implies selected with output enable off
   a_r2_write_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_cs_n && mem_oe_n));

   // R2: deselected means every strobe inactive
   a_r2_deselect_mode: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n |-> (mem_we_n && mem_oe_n));

   // R7: never drive the bus while the memory may drive it
   a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R8: busy status follows the strobes being active
   a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !ready);

   generate
      if (TURN_CYC > 0) begin : g_turn_chk
         // R6: read enable never directly after a driven cycle
         a_r6_gap_before_read: assert property (@(posedge clk) disable iff (!rst_n)
            !mem_oe_n |-> !$past(mem_dq_oe));
         // R6: driver never directly after a read cycle
         a_r6_gap_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
            mem_dq_oe |-> $past(mem_oe_n));
      end
      if (WR_HOLD > 0) begin : g_hold_chk
         // R4: at the end of the write strobe, address and data are still held
         a_r4_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));
      end
   endgenerate

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

   localparam int AW   = 6;
   localparam int DW   = 8;
   localparam int RD   = 2;
   localparam int WR   = 2;
   localparam int HOLD = 1;
   localparam int TURN = 1;
   localparam int NW   = 1 << AW;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic          req, req_we;
   logic [AW-1:0] req_addr;
   logic [DW-1:0] req_wdata;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_done, ready;
   logic [AW-1:0] mem_addr;
   logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DW-1:0] mem_dq_out, mem_dq_in;

   asram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WR_CYC(WR),
      .WR_HOLD(HOLD), .TURN_CYC(TURN)
   ) u_asram_ctrl (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
      .rsp_done(rsp_done), .ready(ready), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   int nchk = 0;
   int nfail = 0;
   logic [DW-1:0] model [NW];
   logic [DW-1:0] expect_mem [NW];
   bit            have_prev = 0;
   bit            last_w = 0;
   logic [DW-1:0] last_rd = '0;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // behavioural memory: stores at end of write, drives only in read mode
   logic wr_act;
   assign wr_act    = !mem_cs_n && !mem_we_n;
   assign mem_dq_in = (!mem_cs_n && mem_we_n && !mem_oe_n) ? model[mem_addr] : '0;
   always @(negedge wr_act) model[mem_addr] = mem_dq_out;

   // pin monitor
   int            we_run = 0, rd_run = 0;
   bit            prev_drv = 0, prev_rd = 0;
   logic [AW-1:0] prev_addr;
   logic [DW-1:0] prev_dout;
   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit rd_m = !mem_cs_n && mem_we_n && !mem_oe_n;
         automatic bit wr_m = !mem_cs_n && !mem_we_n;
         if (wr_m) chk(mem_oe_n, "R2 oe high in write", mem_oe_n, 1);
         if (rd_m && rd_run == 0) chk(!prev_drv, "R6 gap before read", prev_drv, 0);
         if (mem_dq_oe && !prev_drv) chk(!prev_rd, "R6 gap before drive", prev_rd, 0);
         if (mem_dq_oe) chk(mem_oe_n && !rd_m, "R7 contention", rd_m, 0);
         if (!wr_m && we_run > 0) begin
            chk(we_run == WR, "R4 write strobe length", we_run, WR);
            chk(mem_dq_oe && mem_addr == prev_addr && mem_dq_out == prev_dout,
                "R4 hold after write", mem_dq_oe, 1);
         end
         if (!rd_m && rd_run > 0) chk(rd_run == RD, "R3 read strobe length", rd_run, RD);
         we_run    = wr_m ? we_run + 1 : 0;
         rd_run    = rd_m ? rd_run + 1 : 0;
         prev_drv  = mem_dq_oe;
         prev_rd   = rd_m;
         prev_addr = mem_addr;
         prev_dout = mem_dq_out;
      end
   end

   task automatic access(input bit w, input int a, input logic [DW-1:0] d, input bit intrude);
      int k;
      int exp_k;
      bit turn;
      turn = have_prev && (last_w != w);
      @(negedge clk);
      while (!ready) @(negedge clk);
      req = 1'b1; req_we = w; req_addr = AW'(a); req_wdata = d;
      @(posedge clk);
      if (w) expect_mem[a] = d;
      have_prev = 1; last_w = w;
      k = 0;
      forever begin
         @(negedge clk);
         if (intrude && k < 2) begin
            req = 1'b1; req_we = 1'b1; req_addr = AW'(5); req_wdata = 8'h11;
            chk(!ready, "R8 ready low while busy", ready, 0);
         end else begin
            req = 1'b0;
         end
         if (rsp_done || k > 30) break;
         @(posedge clk);
         k++;
      end
      exp_k = (w ? WR + HOLD : RD) + (turn ? TURN : 0);
      chk(k == exp_k, turn ? "R6/R9 latency with turnaround" : "R9/R11 latency same direction",
          k, exp_k);
      if (!w) begin
         chk(rsp_rdata == expect_mem[a], "R3 read data", rsp_rdata, expect_mem[a]);
         last_rd = expect_mem[a];
      end else begin
         chk(rsp_rdata == last_rd, "R10 rdata kept over write", rsp_rdata, last_rd);
      end
      @(negedge clk);
      chk(!rsp_done, "R9 done is one cycle", rsp_done, 0);
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int ph);
      return DW'(a * 29 + ph * 71 + 3);
   endfunction

   initial begin
      #600000;
      nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      req = 0; req_we = 0; req_addr = '0; req_wdata = '0;
      rst_n = 1'b0;
      for (int i = 0; i < NW; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes idle in reset",
          {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
      chk(ready && !rsp_done, "R1 handshake in reset", {ready, rsp_done}, 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && ready && !rsp_done,
          "R1 idle after reset", {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, ready}, 5'b11101);

      // R11: full write sweep then full read sweep
      for (int a = 0; a < NW; a++) access(1'b1, a, pat(a, 0), 1'b0);
      for (int a = 0; a < NW; a++) access(1'b0, a, '0, 1'b0);
      // R6: alternating directions, descending addresses
      for (int a = NW - 1; a >= 0; a--) begin
         access(1'b1, a, pat(a, 1), 1'b0);
         access(1'b0, a, '0, 1'b0);
      end
      // R8: request raised while busy is ignored
      access(1'b1, 3, 8'hA5, 1'b1);
      repeat (4) @(negedge clk);
      chk(mem_cs_n && ready, "R8 no extra access", {mem_cs_n, ready}, 2'b11);
      access(1'b0, 5, '0, 1'b0);
      access(1'b0, 3, '0, 1'b0);
      access(1'b0, NW - 1, '0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule